// File: doc/BRIEF.md
# Zoned Bus Cycle Timing Sequencer

This block sits between a CPU request port and an on-chip bus. It serves flash, RAM and peripherals. Each request address is decoded into one of four zones, or into "unmapped". The zones are flash, RAM, a general peripheral range and a small I/O window with its own timing register. The sequencer then plays out the access one clock at a time. An access can have a single leading idle cycle, then a strobe phase (the access cycle plus its wait cycles), then hold cycles with the strobe low. A one-clock ready pulse goes back to the CPU on the final cycle.

The number of wait and hold cycles depends on several things together: the zone, whether the access is a read or a write, the fast-read enable, and the early/late write select. A leading idle cycle is added in three cases:
- The access targets a peripheral.
- The access targets the I/O window and that window's lead-idle bit is set.
- The zone differs from the last completed access, and either the preliminary-idle enable is set or the previous access left a post-idle request behind.

Two configuration registers are loaded through a simple write port. The timing of each access is fixed from their contents at the moment the request is accepted.

Top module: `zone_bus_seq`

## Requirements
- R1: Zone decode uses fixed priority. Flash covers 0x000000–0x03FFFF and 0x0E0000–0x0E1FFF, and flash is checked before RAM. RAM covers 0x0E0000–0x0E7FFF and 0x0E8000–0x0E91FF. The I/O window covers 0xFFFB00–0xFFFBFF and is checked before the peripheral range. The peripheral range covers 0x0EF000–0x0EF1FF and 0xFF0000–0xFFFBFF. Every other address is unmapped.
- R2: With fast-read set, a flash read drives the read strobe for exactly one cycle, with ready in that same cycle and no hold cycles.
- R3: With fast-read clear, a flash read drives the read strobe for 1 + (WAITSEL+1) cycles, then HOLD cycles with both strobes low. Ready is high on the last of these cycles.
- R4: With fast-read set, a flash write drives the write strobe for 2 cycles (one wait) and has no hold cycles.
- R5: With fast-read clear, a flash write has WAITSEL+1 wait cycles when early-write is clear, or WAITSEL+2 when it is set, followed by HOLD hold cycles.
- R6: A RAM access drives its strobe for one cycle with ready in that cycle, whatever the flash timing fields hold.
- R7: Every peripheral access has one idle cycle with both strobes low, then 2 strobe cycles, and no hold cycles.
- R8: An I/O-window access takes IOWAIT wait cycles and IOHOLD hold cycles from the I/O register. It has a leading idle cycle whenever that register's lead-idle bit is set.
- R9: With preliminary-idle set, an access whose zone differs from the last completed mapped access gets one leading idle cycle. An access to the same zone gets none. The first access after reset always counts as a zone change.
- R10: An access that completes while post-idle is set makes the next access in a different zone start with one idle cycle. The next access in the same zone gets none. No access ever has more than one idle cycle.
- R11: Ready is a single-cycle pulse. A request is accepted only in the cycle after the sequencer returns to rest. During reset, all outputs are low. An unmapped request completes in the cycle after acceptance with no strobe, and it leaves the zone history and the post-idle request unchanged.
- R12: The configuration port works as follows:
  - A write with `cfg_sel`=0 loads the zone register: bit0 fast-read, bits3:1 WAITSEL, bits5:4 HOLD, bit6 early-write, bit7 preliminary-idle, bit8 post-idle. Its reset value is 0.
  - A write with `cfg_sel`=1 loads the I/O register from bits5:0: bits2:0 IOWAIT, bits4:3 IOHOLD, bit5 lead-idle. Its reset value is IOWAIT=1, IOHOLD=0, lead-idle=1.
  - A write takes effect for the next accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 1 | Register select: 0 zone timing, 1 I/O window timing |
| cfg_wdata | input | 9 | Configuration write data |
| req_valid | input | 1 | CPU request valid, held until ready |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 24 | Request byte address |
| req_ready | output | 1 | One-cycle completion pulse |
| bus_rd_stb | output | 1 | Read strobe during access and wait cycles |
| bus_wr_stb | output | 1 | Write strobe during access and wait cycles |
| bus_addr | output | 24 | Address of the access in progress |

## Verification
A wrong wait or hold counter shows up within the same access. The strobe runs too long or too short, or the ready pulse moves by one or more cycles, so a per-cycle comparison catches it before the access completes. A corrupted zone history or post-idle flag shows nothing during the access that sets it. It appears only on the next access, as a missing or extra idle cycle in its first clock after acceptance. The bench therefore steps through sequences that deliberately cross zones, stay within a zone, and pass through an unmapped address.

// File: rtl/zbs_pkg.sv
// Shared types and constants for the zoned bus cycle sequencer.
// Assumes a 24-bit byte address space and at most 9 wait cycles per access.
package zbs_pkg;
    localparam int ADDR_W = 24;
    localparam int CNT_W  = 4;
    localparam int CFG_W  = 9;

    typedef enum logic [2:0] {
        Z_NONE   = 3'd0,
        Z_FLASH  = 3'd1,
        Z_RAM    = 3'd2,
        Z_PERIPH = 3'd3,
        Z_IO     = 3'd4
    } zone_e;

    // Zone timing register, LSB first: fast_rd, wait_sel, hold_n, early_wr, pre_idle, post_idle
    typedef struct packed {
        logic       post_idle;
        logic       pre_idle;
        logic       early_wr;
        logic [1:0] hold_n;
        logic [2:0] wait_sel;
        logic       fast_rd;
    } zone_cfg_t;

    // I/O window timing register, LSB first: wait_n, hold_n, lead_idle
    typedef struct packed {
        logic       lead_idle;
        logic [1:0] hold_n;
        logic [2:0] wait_n;
    } io_cfg_t;

    localparam io_cfg_t IO_CFG_RST = '{lead_idle: 1'b1, hold_n: 2'd0, wait_n: 3'd1};

    function automatic logic in_span(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] lo,
                                     input logic [ADDR_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction
endpackage

// File: rtl/zbs_zone_dec.sv
// Address-to-zone decoder.
// Does: maps an address onto flash, RAM, I/O window, peripheral or none.
// Assumes: flash outranks RAM where they overlap; the I/O window outranks peripherals.
module zbs_zone_dec
    import zbs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] FL_A_LO = 24'h000000,
    parameter logic [ADDR_W-1:0] FL_A_HI = 24'h03FFFF,
    parameter logic [ADDR_W-1:0] FL_B_LO = 24'h0E0000,
    parameter logic [ADDR_W-1:0] FL_B_HI = 24'h0E1FFF,
    parameter logic [ADDR_W-1:0] RM_A_LO = 24'h0E0000,
    parameter logic [ADDR_W-1:0] RM_A_HI = 24'h0E7FFF,
    parameter logic [ADDR_W-1:0] RM_B_LO = 24'h0E8000,
    parameter logic [ADDR_W-1:0] RM_B_HI = 24'h0E91FF,
    parameter logic [ADDR_W-1:0] IO_LO   = 24'hFFFB00,
    parameter logic [ADDR_W-1:0] IO_HI   = 24'hFFFBFF,
    parameter logic [ADDR_W-1:0] PR_A_LO = 24'h0EF000,
    parameter logic [ADDR_W-1:0] PR_A_HI = 24'h0EF1FF,
    parameter logic [ADDR_W-1:0] PR_B_LO = 24'hFF0000,
    parameter logic [ADDR_W-1:0] PR_B_HI = 24'hFFFBFF
) (
    input  logic [ADDR_W-1:0] addr,
    output zone_e             zone
);
    // Priority-ordered range match
    always_comb begin
        if (in_span(addr, FL_A_LO, FL_A_HI) || in_span(addr, FL_B_LO, FL_B_HI))
            zone = Z_FLASH;
        else if (in_span(addr, RM_A_LO, RM_A_HI) || in_span(addr, RM_B_LO, RM_B_HI))
            zone = Z_RAM;
        else if (in_span(addr, IO_LO, IO_HI))
            zone = Z_IO;
        else if (in_span(addr, PR_A_LO, PR_A_HI) || in_span(addr, PR_B_LO, PR_B_HI))
            zone = Z_PERIPH;
        else
            zone = Z_NONE;
    end

    // Overlap priority checks (R1)
    always_comb begin
        if (in_span(addr, FL_B_LO, FL_B_HI))
            p_flash_over_ram_r1: assert (zone == Z_FLASH);
        if (in_span(addr, IO_LO, IO_HI))
            p_io_over_periph_r1: assert (zone == Z_IO);
    end
endmodule

// File: rtl/zbs_cfg_regs.sv
// Configuration register pair.
// Does: holds zone timing and I/O window timing, loaded through a write port.
// Assumes: cfg_sel picks the register; the unused upper bits are ignored for the I/O register.
module zbs_cfg_regs
    import zbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             sel,
    input  logic [CFG_W-1:0] wdata,
    output zone_cfg_t        zcfg,
    output io_cfg_t          iocfg
);
    localparam int IO_W = $bits(io_cfg_t);

    // Register load with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zcfg  <= '0;
            iocfg <= IO_CFG_RST;
        end else if (we) begin
            if (sel) iocfg <= io_cfg_t'(wdata[IO_W-1:0]);
            else     zcfg  <= zone_cfg_t'(wdata);
        end
    end
endmodule

// File: rtl/zbs_cycle_plan.sv
// Access timing planner.
// Does: turns zone, direction and configuration into an idle flag, a wait count and a hold count.
// Assumes: at most one idle cycle per access; counts fit in CNT_W bits.
module zbs_cycle_plan
    import zbs_pkg::*;
(
    input  zone_e            zone,
    input  logic             is_wr,
    input  zone_cfg_t        zcfg,
    input  io_cfg_t          iocfg,
    input  logic             zone_change,
    input  logic             post_pend,
    output logic             lead_idle,
    output logic [CNT_W-1:0] waits,
    output logic [1:0]       holds
);
    // Wait and hold counts per zone
    always_comb begin
        waits = '0;
        holds = '0;
        case (zone)
            Z_FLASH: begin
                if (zcfg.fast_rd) begin
                    waits = is_wr ? CNT_W'(1) : '0;
                end else begin
                    waits = CNT_W'(zcfg.wait_sel) + CNT_W'(1) + CNT_W'(is_wr && zcfg.early_wr);
                    holds = zcfg.hold_n;
                end
            end
            Z_PERIPH: waits = CNT_W'(1);
            Z_IO: begin
                waits = CNT_W'(iocfg.wait_n);
                holds = iocfg.hold_n;
            end
            default: ;
        endcase
    end

    // Single leading idle cycle decision
    always_comb begin
        lead_idle = (zone != Z_NONE) &&
                    ((zone == Z_PERIPH) ||
                     (zone == Z_IO && iocfg.lead_idle) ||
                     (zone_change && (zcfg.pre_idle || post_pend)));
    end

    // Fast flash read and RAM are single-cycle (R2, R6)
    always_comb begin
        if (zone == Z_FLASH && !is_wr && zcfg.fast_rd)
            p_fast_read_single_r2: assert (waits == '0 && holds == '0);
        if (zone == Z_RAM)
            p_ram_no_stretch_r6: assert (waits == '0 && holds == '0);
    end
endmodule

// File: rtl/zone_bus_seq.sv
// Zoned bus cycle timing sequencer (top).
// Does: accepts one CPU request at a time, then steps through idle, strobe and hold
//       cycles, and pulses ready on the final cycle.
// Assumes: req_valid and its fields are held until req_ready; timing is fixed at acceptance.
module zone_bus_seq
    import zbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              bus_rd_stb,
    output logic              bus_wr_stb,
    output logic [ADDR_W-1:0] bus_addr
);
    typedef enum logic [2:0] {ST_REST, ST_GAP, ST_ACC, ST_HOLD, ST_SKIP} st_e;

    st_e               st;
    zone_e             dec_zone, cur_zone, last_zone;
    zone_cfg_t         zcfg;
    io_cfg_t           iocfg;
    logic              cur_wr, post_pend, lead_idle, done;
    logic [CNT_W-1:0]  waits, wcnt;
    logic [1:0]        holds, hcnt;
    logic [ADDR_W-1:0] addr_q;

    zbs_zone_dec u_dec (
        .addr (req_addr),
        .zone (dec_zone)
    );

    zbs_cfg_regs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .zcfg  (zcfg),
        .iocfg (iocfg)
    );

    zbs_cycle_plan u_plan (
        .zone        (dec_zone),
        .is_wr       (req_write),
        .zcfg        (zcfg),
        .iocfg       (iocfg),
        .zone_change (dec_zone != last_zone),
        .post_pend   (post_pend),
        .lead_idle   (lead_idle),
        .waits       (waits),
        .holds       (holds)
    );

    // Final cycle of an access
    always_comb begin
        done = (st == ST_ACC && wcnt == '0 && hcnt == '0) ||
               (st == ST_HOLD && hcnt == 2'd1) ||
               (st == ST_SKIP);
    end

    // Sequencer state, counters and latched request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_REST;
            wcnt     <= '0;
            hcnt     <= '0;
            cur_zone <= Z_NONE;
            cur_wr   <= 1'b0;
            addr_q   <= '0;
        end else begin
            case (st)
                ST_REST: if (req_valid) begin
                    addr_q   <= req_addr;
                    cur_wr   <= req_write;
                    cur_zone <= dec_zone;
                    wcnt     <= waits;
                    hcnt     <= holds;
                    if (dec_zone == Z_NONE) st <= ST_SKIP;
                    else if (lead_idle)     st <= ST_GAP;
                    else                    st <= ST_ACC;
                end
                ST_GAP: st <= ST_ACC;
                ST_ACC: begin
                    if (wcnt != '0)      wcnt <= wcnt - CNT_W'(1);
                    else if (hcnt != '0) st   <= ST_HOLD;
                    else                 st   <= ST_REST;
                end
                ST_HOLD: begin
                    if (hcnt == 2'd1) st   <= ST_REST;
                    else              hcnt <= hcnt - 2'd1;
                end
                default: st <= ST_REST;
            endcase
        end
    end

    // Zone history and pending post-idle, updated on mapped completions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_zone <= Z_NONE;
            post_pend <= 1'b0;
        end else if (done && st != ST_SKIP) begin
            last_zone <= cur_zone;
            post_pend <= zcfg.post_idle;
        end
    end

    // Output drive
    always_comb begin
        req_ready  = done;
        bus_rd_stb = (st == ST_ACC) && !cur_wr;
        bus_wr_stb = (st == ST_ACC) && cur_wr;
        bus_addr   = addr_q;
    end

    p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd_stb && bus_wr_stb));
    p_addr_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_REST && !req_ready) |=> $stable(bus_addr));
    p_idle_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_GAP) |=> (st == ST_ACC));
    p_ram_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACC && cur_zone == Z_RAM) |-> req_ready);
    p_skip_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP) |=> (st == ST_REST && $stable(last_zone)));
endmodule

// File: tb/sim_zone_bus_seq.sv
// Bench: a behavioural per-cycle model queues the expected {rd, wr, ready} values,
// and the bench compares them against the design on every falling edge.
module sim_zone_bus_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 20000;

    logic        clk, rst_n, cfg_we, cfg_sel, req_valid, req_write;
    logic [8:0]  cfg_wdata;
    logic [23:0] req_addr, bus_addr;
    logic        req_ready, bus_rd_stb, bus_wr_stb;

    int          n_cmp, n_bad;
    logic [2:0]  expq[$];
    logic [23:0] cur_addr;
    int          m_last;
    bit          m_post;
    bit [8:0]    m_zcfg;
    bit [5:0]    m_io;

    zone_bus_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_ready(req_ready), .bus_rd_stb(bus_rd_stb),
        .bus_wr_stb(bus_wr_stb), .bus_addr(bus_addr)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Zone codes of the model: 0 none, 1 flash, 2 RAM, 3 peripheral, 4 I/O window
    function automatic int zone_of(input logic [23:0] a);
        if (a <= 24'h03FFFF || (a >= 24'h0E0000 && a <= 24'h0E1FFF)) return 1;
        if ((a >= 24'h0E0000 && a <= 24'h0E7FFF) || (a >= 24'h0E8000 && a <= 24'h0E91FF)) return 2;
        if (a >= 24'hFFFB00 && a <= 24'hFFFBFF) return 4;
        if ((a >= 24'h0EF000 && a <= 24'h0EF1FF) || (a >= 24'hFF0000 && a <= 24'hFFFBFF)) return 3;
        return 0;
    endfunction

    task automatic tick(input string tag);
        logic [2:0] exp_v, act_v;
        @(negedge clk);
        exp_v = (expq.size() != 0) ? expq.pop_front() : 3'b000;
        act_v = {bus_rd_stb, bus_wr_stb, req_ready};
        n_cmp++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s t=%0t {rd,wr,rdy} actual %b expected %b", tag, $time, act_v, exp_v);
        end else if ((bus_rd_stb || bus_wr_stb) && bus_addr !== cur_addr) begin
            n_bad++;
            $display("FAIL %s t=%0t bus_addr actual %h expected %h", tag, $time, bus_addr, cur_addr);
        end
    endtask

    task automatic wr_cfg(input bit sel, input bit [8:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        tick("R12");
        cfg_we = 1'b0;
        if (sel) m_io = d[5:0]; else m_zcfg = d;
    endtask

    task automatic do_req(input logic [23:0] a, input bit w, input string tag);
        int z, nw, nh, n;
        bit idle, chg;
        logic [2:0] stb;
        z   = zone_of(a);
        chg = (z != m_last);
        nw = 0; nh = 0;
        case (z)
            1: if (m_zcfg[0]) nw = w ? 1 : 0;
               else begin
                   nw = int'(m_zcfg[3:1]) + 1 + ((w && m_zcfg[6]) ? 1 : 0);
                   nh = int'(m_zcfg[5:4]);
               end
            3: nw = 1;
            4: begin nw = int'(m_io[2:0]); nh = int'(m_io[4:3]); end
            default: ;
        endcase
        idle = (z == 3) || (z == 4 && m_io[5]) || (z != 0 && chg && (m_zcfg[7] || m_post));
        stb  = w ? 3'b010 : 3'b100;
        if (z == 0) expq.push_back(3'b001);
        else begin
            if (idle) expq.push_back(3'b000);
            for (int i = 0; i <= nw; i++) expq.push_back(stb);
            for (int i = 0; i < nh; i++) expq.push_back(3'b000);
            expq[expq.size()-1][0] = 1'b1;
        end
        req_valid = 1'b1; req_addr = a; req_write = w; cur_addr = a;
        n = expq.size();
        for (int i = 0; i < n; i++) tick(tag);
        req_valid = 1'b0;
        if (z != 0) begin m_last = z; m_post = m_zcfg[8]; end
        tick(tag);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * WDOG_CYC);
        n_bad++;
        $display("FAIL R11 watchdog: cycles actual %0d expected below %0d", WDOG_CYC, WDOG_CYC);
        summary();
        $finish;
    end

    initial begin
        n_cmp = 0; n_bad = 0; m_last = 0; m_post = 0; m_zcfg = '0; m_io = 6'h21;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; cur_addr = '0;
        repeat (3) tick("R11");            // reset state: all outputs low
        rst_n = 1'b1;
        tick("R11");
        // R9: preliminary idle on zone change; first access counts as a change
        wr_cfg(1'b0, 9'h080);
        do_req(24'h000100, 1'b0, "R9");
        do_req(24'h000104, 1'b0, "R9");
        do_req(24'h0E4000, 1'b0, "R9");
        // R3: slow flash read, WAITSEL=3, HOLD=2
        wr_cfg(1'b0, 9'h026);
        do_req(24'h000200, 1'b0, "R3");
        // R5: late then early flash write
        do_req(24'h03FFF0, 1'b1, "R5");
        wr_cfg(1'b0, 9'h066);
        do_req(24'h03FFF0, 1'b1, "R5");
        // R1: overlapping address takes flash timing
        do_req(24'h0E1000, 1'b0, "R1");
        // R6: RAM single cycle despite slow timing
        do_req(24'h0E8100, 1'b1, "R6");
        do_req(24'h0E91FF, 1'b0, "R6");
        // R2 / R4: fast flash read and write
        wr_cfg(1'b0, 9'h001);
        do_req(24'h000000, 1'b0, "R2");
        do_req(24'h010000, 1'b1, "R4");
        // R7: peripherals, both ranges
        do_req(24'h0EF010, 1'b0, "R7");
        do_req(24'hFF1234, 1'b1, "R7");
        // R8: I/O window, reset timing then reprogrammed
        do_req(24'hFFFB40, 1'b0, "R8");
        wr_cfg(1'b1, 9'h00B);
        do_req(24'hFFFB40, 1'b0, "R8");
        do_req(24'hFFFB00, 1'b1, "R1");
        do_req(24'hFFFAFF, 1'b0, "R1");
        do_req(24'hFFFC00, 1'b0, "R1");
        // R10: post idle
        wr_cfg(1'b0, 9'h101);
        do_req(24'h000300, 1'b0, "R10");
        do_req(24'h0E2000, 1'b0, "R10");
        do_req(24'h0E2004, 1'b0, "R10");
        // R11: unmapped request leaves history alone
        wr_cfg(1'b0, 9'h080);
        do_req(24'h800000, 1'b0, "R11");
        do_req(24'h0E2008, 1'b1, "R11");
        // R12: reprogramming applies to the next request
        wr_cfg(1'b0, 9'h03E);
        do_req(24'h000010, 1'b0, "R12");
        repeat (2) tick("R11");
        summary();
        $finish;
    end
endmodule